// File: doc/BRIEF.md
# Bit Timing Recovery Digital PLL

This block recovers a receive bit clock from a hard-decided serial data stream at nominally 1200 bit/s, running from a 3.6864 MHz master clock. A free-running phase counter of `PERIOD` master cycles (3072 by default) defines one bit. Counter value 0 marks the place where a data transition is expected, and the midpoint marks the 180-degree sampling instant.

The raw input first passes a two-flop synchronizer and a three-sample majority filter. Each transition of the filtered stream is compared against the counter to give a signed phase error. The counter is then pulled toward the transition by a slow step, or by a fast step while the error is large. The size of the fast step depends on the selected lock-in budget.

The recovered clock is high in the first half of the bit and low in the second. The retimed data output takes the filtered value on the falling edge of the recovered clock. It therefore changes exactly as that clock falls, well within 300 ns of that edge.

Top module: `bit_clock_recovery`

## Requirements
- R1: Under reset `rclk` is 1 and `rxd` is 0. With no input transitions, `rclk` rises on the `PERIOD`-th clock edge after reset release and then every `PERIOD` edges. It is high while the counter is below `PERIOD/2`.
- R2: `rx_data` passes two synchronizing flops and then a majority vote over three consecutive samples. A pulse lasting one clock cycle changes neither the clock timing nor `rxd`.
- R3: A level change of `rx_data` between clock edges k and k+1 is judged against the counter value c held after edge k+3, and the correction takes effect at edge k+4. If c < `PERIOD/2`, the error is e = c and the counter is set to c+1-step. Otherwise e = `PERIOD`-c and the counter is set to c+1+step. When e = 0 there is no correction.
- R4: The slow step is e/64 (truncated) and never less than 1. It is used whenever e is at most `PERIOD/16`, which is 22.5 degrees.
- R5: When `fast_en` is 1 and e exceeds `PERIOD/16`, the step is e/2 if `lock_sel` is 0 and e/8 if `lock_sel` is 1.
- R6: When `fast_en` is 0, only the slow step is used, whatever the size of e.
- R7: `rxd` changes only on the clock edge where `rclk` falls. At that edge it takes the filtered input value.
- R8: With `fast_en` = 1 and alternating data starting at a 180-degree error, the phase error is within `PERIOD/16`. This holds after at most 18 transitions when `lock_sel` = 0, and after at most 50 transitions when `lock_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 1 | Demodulated hard-decision data, asynchronous |
| fast_en | input | 1 | 1 allows the fast correction step for large errors |
| lock_sel | input | 1 | 0 selects the 18-bit lock budget (half step), 1 selects the 50-bit budget (eighth step) |
| rclk | output | 1 | Recovered bit clock |
| rxd | output | 1 | Retimed data, updated as `rclk` falls |

## Verification
The phase counter is visible only through the timing of `rclk` edges. A wrong step size or a wrong error sign therefore appears as an `rclk` rising edge displaced by a known number of cycles, one bit period after the offending transition. The bench predicts every rising edge to the exact cycle, so an off-by-one in the step, the threshold or the detection latency is caught within one bit. A fault in the majority filter or the sampling point shows up at the next falling edge of `rclk` as a wrong `rxd` value.

// File: rtl/bit_clock_recovery.sv
module bit_clock_recovery #(
  parameter int PERIOD     = 3072,
  parameter int SLOW_SHIFT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_data,
  input  logic fast_en,
  input  logic lock_sel,
  output logic rclk,
  output logic rxd
);
  localparam int CW  = $clog2(PERIOD);
  localparam int CW1 = CW + 1;
  localparam logic [CW-1:0] HALF_C   = CW'(PERIOD / 2);
  localparam logic [CW-1:0] THRESH_C = CW'(PERIOD / 16);
  localparam logic [CW:0]   PERIOD_W = CW1'(PERIOD);

  logic s1, s2, h1, h2, maj, maj_q, edge_seen, late, hi_next;
  logic [CW-1:0] phase_cnt, err, step, slow_raw, fast_step;
  logic [CW:0]   sum, nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, h1, h2, maj_q} <= '0;
    else begin
      s1    <= rx_data;
      s2    <= s1;
      h1    <= s2;
      h2    <= h1;
      maj_q <= maj;
    end

  assign maj       = (s2 & h1) | (s2 & h2) | (h1 & h2);
  assign edge_seen = maj ^ maj_q;

  assign late      = phase_cnt >= HALF_C;
  assign err       = late ? CW'(PERIOD_W - {1'b0, phase_cnt}) : phase_cnt;
  assign slow_raw  = err >> SLOW_SHIFT;
  assign fast_step = lock_sel ? (err >> 3) : (err >> 1);

  always_comb begin
    if (err == '0)                     step = '0;
    else if (fast_en && err > THRESH_C) step = fast_step;
    else if (slow_raw == '0)           step = CW'(1);
    else                               step = slow_raw;
  end

  always_comb begin
    sum = {1'b0, phase_cnt} + CW1'(1);
    if (edge_seen) sum = late ? sum + {1'b0, step} : sum - {1'b0, step};
    nxt = (sum >= PERIOD_W) ? sum - PERIOD_W : sum;
  end

  assign hi_next = nxt < {1'b0, HALF_C};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_cnt <= '0;
      rclk      <= 1'b1;
      rxd       <= 1'b0;
    end else begin
      phase_cnt <= nxt[CW-1:0];
      rclk      <= hi_next;
      if (rclk && !hi_next) rxd <= maj;
    end
endmodule

module bit_clock_recovery_chk #(
  parameter int PERIOD     = 3072,
  parameter int SLOW_SHIFT = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(PERIOD)-1:0]  cnt,
  input logic                       edge_seen,
  input logic                       fast_en,
  input logic                       rclk,
  input logic                       rxd
);
  localparam int CW  = $clog2(PERIOD);
  localparam int CW1 = CW + 1;
  localparam logic [CW-1:0] HALF_C   = CW'(PERIOD / 2);
  localparam logic [CW-1:0] THRESH_C = CW'(PERIOD / 16);
  localparam logic [CW-1:0] LAST_C   = CW'(PERIOD - 1);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < CW1'(PERIOD));

  // R1
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && cnt == LAST_C) |=> (cnt == '0 && rclk));

  // R1
  free_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && cnt != LAST_C) |=> (cnt == $past(cnt) + CW'(1)));

  // R6
  slow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !fast_en && cnt != '0 && cnt < HALF_C) |=>
      (cnt <= $past(cnt)) && (($past(cnt) - cnt) <= ($past(cnt) >> SLOW_SHIFT)));

  // R5
  fast_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && fast_en && cnt > THRESH_C && cnt < HALF_C) |=>
      (cnt <= $past(cnt) - ($past(cnt) >> 3) + CW'(1)));

  // R7
  rxd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(rclk) |-> $stable(rxd));
endmodule

bind bit_clock_recovery bit_clock_recovery_chk #(.PERIOD(PERIOD), .SLOW_SHIFT(SLOW_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(phase_cnt), .edge_seen(edge_seen),
  .fast_en(fast_en), .rclk(rclk), .rxd(rxd)
);

// File: tb/bit_clock_recovery_bench.sv
module bit_clock_recovery_bench;
  localparam int P = 768;
  localparam int H = P / 2;
  localparam int T = P / 16;
  localparam int S = 6;

  logic clk = 0, rst_n = 0, rx_data = 0, fast_en = 0, lock_sel = 0;
  logic rclk, rxd, rclk_prev = 1;
  int cyc = 0, nerr = 0, nchk = 0;
  int base, nr, chg = -1000, lvl = 0, prev_lvl = 0, last_rise = 0;
  int e_rise, want;
  string r_req;
  bit exact = 0;
  int exp_q[$];
  string req_q[$];

  always #5 clk = ~clk;

  bit_clock_recovery #(.PERIOD(P), .SLOW_SHIFT(S)) u_bit_clock_recovery (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .fast_en(fast_en),
    .lock_sel(lock_sel), .rclk(rclk), .rxd(rxd)
  );

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected rising-edge cycles, checks rxd at each fall
  always @(negedge clk) begin
    if (rst_n) begin
      if (rclk && !rclk_prev) begin
        last_rise = cyc;
        if (exact) begin
          if (exp_q.size() == 0) check(1'b0, "R1 unexpected rclk rise", cyc, -1);
          else begin
            e_rise = exp_q.pop_front();
            r_req  = req_q.pop_front();
            check(cyc == e_rise, r_req, cyc, e_rise);
          end
        end
      end
      if (!rclk && rclk_prev && exact) begin
        want = (cyc - 1 >= chg + 3) ? lvl : prev_lvl;
        check(int'(rxd) == want, "R7 retimed data at rclk fall", int'(rxd), want);
      end
    end
    rclk_prev = rclk;
  end

  // driver: transition judged at counter value off, expected next rise queued
  task automatic edge_at(input int off, input bit f, input bit l, input string req);
    int m, e, st, nc;
    m = nr + off - 3;
    while (cyc < m) @(negedge clk);
    fast_en = f; lock_sel = l;
    prev_lvl = lvl; lvl = 1 - lvl; rx_data = lvl[0]; chg = m;
    e = (off < H) ? off : P - off;
    if (e == 0) st = 0;
    else if (f && e > T) st = l ? (e >> 3) : (e >> 1);
    else st = ((e >> S) > 0) ? (e >> S) : 1;
    nc = (off < H) ? off + 1 - st : off + 1 + st;
    if (nc >= P) nc = nc - P;
    base = m + 4 - nc;
    nr = base + P;
    exp_q.push_back(nr); req_q.push_back(req);
  endtask

  task automatic glitch_at(input int off);
    int m;
    m = nr + off - 3;
    while (cyc < m) @(negedge clk);
    rx_data = ~lvl[0];
    @(negedge clk);
    rx_data = lvl[0];
    base = nr; nr = base + P;
    exp_q.push_back(nr); req_q.push_back("R2 one-cycle glitch ignored");
  endtask

  task automatic lock_run(input bit l, input int nbits, input string req);
    int m, c, e;
    exact = 0; rst_n = 0; rx_data = 0; lvl = 0;
    repeat (4) @(negedge clk);
    fast_en = 1; lock_sel = l; rst_n = 1;
    m = 0;
    for (int k = 0; k <= nbits; k++) begin
      m = H + k * P - 3;
      while (cyc < m) @(negedge clk);
      if (k < nbits) begin lvl = 1 - lvl; rx_data = lvl[0]; end
    end
    while (cyc < m + 3) @(negedge clk);
    #1;
    c = ((m + 3 - last_rise) % P + P) % P;
    e = (c < H) ? c : P - c;
    check(e <= T, req, e, T);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(rclk == 1'b1, "R1 rclk level in reset", int'(rclk), 1);
    check(rxd == 1'b0, "R1 rxd level in reset", int'(rxd), 0);
    base = 0; nr = P; exact = 1;
    exp_q.push_back(P); req_q.push_back("R1 first free-running rise");
    rst_n = 1;
    edge_at(100, 0, 0, "R4 slow step e/64");
    edge_at(20, 0, 0, "R4 slow step minimum of 1");
    edge_at(568, 0, 0, "R6 fast disabled, large error uses slow step");
    edge_at(568, 1, 0, "R5 fast half step, late transition");
    edge_at(200, 1, 1, "R5 fast eighth step, early transition");
    edge_at(48, 1, 0, "R4 error at threshold stays slow");
    edge_at(49, 1, 0, "R5 error just above threshold goes fast");
    glitch_at(300);
    edge_at(720, 1, 1, "R3 late-side error sign, slow step");
    while (cyc < nr + 8) @(negedge clk);
    check(exp_q.size() == 0, "R1 all predicted rises seen", exp_q.size(), 0);
    exact = 0;
    lock_run(0, 18, "R8 lock within 18 transitions, lock_sel=0");
    lock_run(1, 50, "R8 lock within 50 transitions, lock_sel=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #1_500_000;
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule